// File: doc/BRIEF.md
# Pipeline Hazard Interlock and Bypass Unit

This block is the data-hazard controller of an in-order integer pipeline with five stages: fetch, decode, execute, memory and writeback. Each cycle it receives the register fields of the instruction sitting in decode. These are the two source indices, a flag per source saying whether that field is really read, the destination index, a write flag and a load flag. It keeps a small record of the destinations of the three older instructions in execute, memory and writeback, and that record advances one stage per clock.

From the record it drives one bypass select per ALU operand. The select tells the operand latch whether to take the register file value or the newest value in flight from execute, memory or writeback. Results of ordinary ALU operations are forwarded with no bubble. The only case that must wait is an instruction that reads the result of a load still in execute. For that case the block raises a stall for exactly one cycle. The stall holds the fetch PC and the decode register, and it places a bubble (no write) into execute. A parameter states whether the register file returns data written in the same cycle. If it does, writeback matches are served by the register file. If it does not, the block selects an extra writeback bypass instead.

Top module: `hazard_unit`

## Requirements
- R1: A source that is read and whose index equals the destination of a valid, writing instruction in execute, memory or writeback selects that stage. Select encoding: 0 = register file, 1 = execute, 2 = memory, 3 = writeback.
- R2: When more than one older stage matches the same source, the youngest one wins: execute over memory over writeback.
- R3: An ALU result in execute is forwarded to the next instruction (select 1) with no stall, so dependent ALU instructions issue back to back.
- R4: If a read source matches a load in execute, `stall` is 1 in that cycle. After one clock, the same decode instruction selects memory (2) with `stall` 0.
- R5: During a stall, execute receives a bubble. A stall therefore never lasts two cycles in a row, and in the cycle after a stall no operand selects execute.
- R6: With WB_WRITE_THROUGH = 0, a writeback match selects 3. With WB_WRITE_THROUGH = 1, it selects 0 (the register file).
- R7: Register index 0 never matches: a source of 0 always selects 0 and never stalls, and writes to index 0 are never forwarded.
- R8: A source whose used flag is 0 selects 0 and never causes a stall, even when a load in execute targets that index.
- R9: After reset, the execute, memory and writeback records are empty. A reset in the middle of a run discards all instructions in flight.
- R10: Load data in memory or writeback is forwarded (select 2 or 3) without a stall.
- R11: When `dec_valid` is 0, both selects are 0, `stall` is 0, and the instruction does not enter the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_rs1 | input | REG_W | First source index |
| dec_rs1_used | input | 1 | First source is read |
| dec_rs2 | input | REG_W | Second source index |
| dec_rs2_used | input | 1 | Second source is read |
| dec_rd | input | REG_W | Destination index |
| dec_wen | input | 1 | Instruction writes its destination |
| dec_load | input | 1 | Instruction is a load |
| fwd_a | output | 2 | Operand A bypass select |
| fwd_b | output | 2 | Operand B bypass select |
| stall | output | 1 | Hold fetch and decode, bubble into execute |

## Verification
A wrong entry in the internal stage record appears at the bypass selects within one to three cycles. It shows up as a select pointing at the wrong stage, or at the register file, when a dependent instruction reaches decode. An entry that is advanced incorrectly shifts the select from execute to memory to writeback at the wrong time. A lost bubble shows up on the next cycle, either as a second stall cycle or as an execute select just after a stall.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int REG_W = 5,
  parameter bit WB_WRITE_THROUGH = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_valid,
  input  logic [REG_W-1:0] dec_rs1,
  input  logic             dec_rs1_used,
  input  logic [REG_W-1:0] dec_rs2,
  input  logic             dec_rs2_used,
  input  logic [REG_W-1:0] dec_rd,
  input  logic             dec_wen,
  input  logic             dec_load,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall
);

  localparam logic [1:0] SEL_RF = 2'd0;
  localparam logic [1:0] SEL_EX = 2'd1;
  localparam logic [1:0] SEL_MEM = 2'd2;
  localparam logic [1:0] SEL_WB = 2'd3;
  localparam logic [1:0] SEL_WBK = WB_WRITE_THROUGH ? SEL_RF : SEL_WB;

  logic [REG_W-1:0] ex_rd, mem_rd, wb_rd;
  logic             ex_we, mem_we, wb_we;
  logic             ex_ld;

  function automatic logic [1:0] pick(input logic used, input logic [REG_W-1:0] rs,
                                      input logic xe, input logic [REG_W-1:0] xr,
                                      input logic me, input logic [REG_W-1:0] mr,
                                      input logic we, input logic [REG_W-1:0] wr);
    if (!used || rs == '0) return SEL_RF;
    if (xe && xr == rs)    return SEL_EX;
    if (me && mr == rs)    return SEL_MEM;
    if (we && wr == rs)    return SEL_WBK;
    return SEL_RF;
  endfunction

  logic [1:0] sel_a, sel_b;
  assign sel_a = pick(dec_rs1_used, dec_rs1, ex_we, ex_rd, mem_we, mem_rd, wb_we, wb_rd);
  assign sel_b = pick(dec_rs2_used, dec_rs2, ex_we, ex_rd, mem_we, mem_rd, wb_we, wb_rd);

  assign fwd_a = dec_valid ? sel_a : SEL_RF;
  assign fwd_b = dec_valid ? sel_b : SEL_RF;
  assign stall = dec_valid && ex_ld && ((sel_a == SEL_EX) || (sel_b == SEL_EX));

  logic enter_we;
  assign enter_we = dec_valid && !stall && dec_wen && (dec_rd != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_rd  <= '0;
      mem_rd <= '0;
      wb_rd  <= '0;
      ex_we  <= 1'b0;
      mem_we <= 1'b0;
      wb_we  <= 1'b0;
      ex_ld  <= 1'b0;
    end else begin
      ex_rd  <= dec_rd;
      ex_we  <= enter_we;
      ex_ld  <= enter_we && dec_load;
      mem_rd <= ex_rd;
      mem_we <= ex_we;
      wb_rd  <= mem_rd;
      wb_we  <= mem_we;
    end
  end

  // R5
  stall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R5
  bubble_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fwd_a != SEL_EX && fwd_b != SEL_EX));

  // R4
  stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> $past(dec_valid && dec_load && dec_wen && !stall));

  // R7
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_rs1 == '0) |-> (fwd_a == SEL_RF));

  // R8
  unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_rs1_used |-> fwd_a == SEL_RF) and (!dec_rs2_used |-> fwd_b == SEL_RF));

  // R11
  idle_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!stall && fwd_a == SEL_RF && fwd_b == SEL_RF));

  generate
    if (WB_WRITE_THROUGH) begin : g_wt
      // R6
      no_wb_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_a != SEL_WB && fwd_b != SEL_WB);
    end
  endgenerate

endmodule

// File: tb/hazard_unit_test.sv
module hazard_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v = 1'b0, u1 = 1'b0, u2 = 1'b0, w = 1'b0, l = 1'b0;
  logic [4:0] rs1 = '0, rs2 = '0, rd = '0;
  logic [1:0] fa, fb, ta, tb;
  logic st, tst;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  hazard_unit #(.REG_W(5), .WB_WRITE_THROUGH(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .dec_valid(v), .dec_rs1(rs1), .dec_rs1_used(u1),
    .dec_rs2(rs2), .dec_rs2_used(u2), .dec_rd(rd), .dec_wen(w), .dec_load(l),
    .fwd_a(fa), .fwd_b(fb), .stall(st));

  hazard_unit #(.REG_W(5), .WB_WRITE_THROUGH(1'b1)) uut_wt (
    .clk(clk), .rst_n(rst_n), .dec_valid(v), .dec_rs1(rs1), .dec_rs1_used(u1),
    .dec_rs2(rs2), .dec_rs2_used(u2), .dec_rd(rd), .dec_wen(w), .dec_load(l),
    .fwd_a(ta), .fwd_b(tb), .stall(tst));

  typedef struct packed {
    logic v; logic [4:0] rs1; logic u1; logic [4:0] rs2; logic u2;
    logic [4:0] rd; logic w; logic l;
    logic [1:0] ea; logic [1:0] eb; logic es; logic [3:0] req;
  } vec_t;

  localparam int N = 16;
  localparam vec_t VEC [N] = '{
    '{1'b1, 5'd3, 1'b1, 5'd5, 1'b1, 5'd1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 4'd1},  // R1 no match
    '{1'b1, 5'd1, 1'b1, 5'd4, 1'b1, 5'd2, 1'b1, 1'b0, 2'd1, 2'd0, 1'b0, 4'd3},  // R3
    '{1'b1, 5'd1, 1'b1, 5'd2, 1'b1, 5'd6, 1'b1, 1'b0, 2'd2, 2'd1, 1'b0, 4'd1},  // R1
    '{1'b1, 5'd1, 1'b1, 5'd6, 1'b1, 5'd7, 1'b1, 1'b0, 2'd3, 2'd1, 1'b0, 4'd6},  // R6
    '{1'b1, 5'd7, 1'b0, 5'd7, 1'b0, 5'd6, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0, 4'd8},  // R8
    '{1'b1, 5'd6, 1'b1, 5'd7, 1'b1, 5'd0, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 4'd2},  // R2
    '{1'b1, 5'd0, 1'b1, 5'd6, 1'b1, 5'd8, 1'b1, 1'b1, 2'd0, 2'd2, 1'b0, 4'd7},  // R7
    '{1'b1, 5'd8, 1'b1, 5'd0, 1'b1, 5'd9, 1'b1, 1'b0, 2'd1, 2'd0, 1'b1, 4'd4},  // R4 stall
    '{1'b1, 5'd8, 1'b1, 5'd0, 1'b1, 5'd9, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 4'd5},  // R5 released
    '{1'b0, 5'd9, 1'b1, 5'd9, 1'b1, 5'd10, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 4'd11}, // R11
    '{1'b1, 5'd10, 1'b1, 5'd9, 1'b1, 5'd11, 1'b1, 1'b1, 2'd0, 2'd2, 1'b0, 4'd11},// R11 not entered
    '{1'b1, 5'd5, 1'b1, 5'd11, 1'b1, 5'd12, 1'b1, 1'b0, 2'd0, 2'd1, 1'b1, 4'd4}, // R4 on b
    '{1'b1, 5'd5, 1'b1, 5'd11, 1'b1, 5'd12, 1'b1, 1'b0, 2'd0, 2'd2, 1'b0, 4'd4}, // R4
    '{1'b1, 5'd11, 1'b1, 5'd12, 1'b0, 5'd13, 1'b1, 1'b1, 2'd3, 2'd0, 1'b0, 4'd10},// R10
    '{1'b1, 5'd13, 1'b0, 5'd13, 1'b0, 5'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 4'd8}, // R8 load ignored
    '{1'b1, 5'd13, 1'b1, 5'd13, 1'b1, 5'd0, 1'b0, 1'b0, 2'd2, 2'd2, 1'b0, 4'd10} // R10
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t x);
    v = x.v; rs1 = x.rs1; u1 = x.u1; rs2 = x.rs2; u2 = x.u2;
    rd = x.rd; w = x.w; l = x.l;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    v = 1'b1; rs1 = 5'd1; u1 = 1'b1; rs2 = 5'd2; u2 = 1'b1; rd = 5'd3; w = 1'b1;
    #2;
    chk("R9", "reset fwd_a", fa, 0);
    chk("R9", "reset fwd_b", fb, 0);
    chk("R9", "reset stall", st, 0);
    v = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #2;
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d fwd_a", i), fa, VEC[i].ea);
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d fwd_b", i), fb, VEC[i].eb);
      chk($sformatf("R%0d", VEC[i].req), $sformatf("vec %0d stall", i), st, VEC[i].es);
      // R6 write-through variant serves writeback matches from the register file
      chk("R6", $sformatf("vec %0d wt fwd_a", i), ta, (VEC[i].ea == 2'd3) ? 0 : VEC[i].ea);
      chk("R6", $sformatf("vec %0d wt fwd_b", i), tb, (VEC[i].eb == 2'd3) ? 0 : VEC[i].eb);
    end
    // R9 reset in the middle of a run drops a load in flight
    @(negedge clk);
    v = 1'b1; rs1 = 5'd0; u1 = 1'b0; rs2 = 5'd0; u2 = 1'b0; rd = 5'd20; w = 1'b1; l = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    w = 1'b0; l = 1'b0; rd = 5'd0; rs1 = 5'd20; u1 = 1'b1;
    #2;
    chk("R9", "mid reset fwd_a", fa, 0);
    chk("R9", "mid reset stall", st, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R9", "after reset fwd_a", fa, 0);
    chk("R9", "after reset stall", st, 0);
    // R7 a write to index 0 is never forwarded
    @(negedge clk);
    rs1 = 5'd0; u1 = 1'b1; rd = 5'd0; w = 1'b1; l = 1'b1;
    @(negedge clk);
    w = 1'b0; l = 1'b0;
    #2;
    chk("R7", "x0 load no stall", st, 0);
    chk("R7", "x0 fwd_a", fa, 0);
    @(negedge clk);
    v = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule